// File: doc/BRIEF.md
# Interrupt Level Mask Manager

This block sits between a set of prioritised interrupt sources and the processor. Each source carries a pending flag and a 3-bit priority level. The block compares each level with a programmable current level mask and raises one interrupt line when any pending request clears the mask. An acknowledge read port returns a vector for the winning request. When no request clears the mask, the port returns a fixed spurious vector instead.

Software reaches three small registers through a register port: the current mask, the saved mask and a configuration word. The configuration word holds an auto-mask enable. With that enable set, an acknowledge that finds a winner raises the current mask to the winner's level in the same clock edge and copies the old mask into the saved register. The service routine can later write the saved value back to the current mask, which lets lower-priority sources interrupt again.

Top module: `irq_level_gate`

## Requirements
- R1: After reset, the current mask reads 0x0F, the saved mask reads 0x00, the configuration word reads 0x00 and `irq_out` is low.
- R2: Registers are selected by `reg_addr`: 0 is the current mask, 1 is the saved mask, 2 is the configuration word with the auto-mask enable in bit 0, and 3 reads as zero. Only bits 3:0 of each mask and bit 0 of the configuration word are stored. All other bits read as zero.
- R3: For a current mask value m from 0 to 7, a pending request of level L asserts `irq_out` exactly when L > m. Mask 7 therefore blocks every level.
- R4: Mask 0xF lets levels 1 to 7 through. Mask values 0x8 to 0xE are kept as written and read back unchanged, but they block every request.
- R5: A request of level 0, or one whose pending flag is low, never asserts `irq_out`.
- R6: `ack_vector` is VEC_BASE (default 0x40) plus the index of the unmasked pending source with the highest level. A tie goes to the lowest index. The output is combinational from the inputs and the current mask.
- R7: If the auto-mask enable is set and an acknowledge finds a winner, then after the clock edge the current mask equals the winner's level and the saved mask equals the previous current mask.
- R8: If the auto-mask enable is clear, an acknowledge changes neither mask register.
- R9: If no unmasked request is pending, `ack_vector` equals SPUR_VEC (default 0x18), and an acknowledge changes neither mask register.
- R10: Writing the saved value back into the current mask restores the filtering that was in force before the acknowledge.
- R11: If a write and an applied mask update fall in the same cycle, the acknowledge update decides both mask registers. If the acknowledge is not applied, the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_pend | input | NSRC | Pending flag per source |
| req_level | input | 3*NSRC | Level per source, source i at bits 3i+2:3i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| ack_req | input | 1 | Acknowledge read strobe |
| ack_vector | output | 8 | Vector of the winning source, or the spurious vector |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A wrong current mask shows at the ports immediately. `irq_out` takes the wrong value for some level, and `ack_vector` names the wrong source or falls back to the spurious code in the same cycle. A wrong saved mask stays hidden until software reads it or writes it back, and then one read shows the error. Mask updates after an acknowledge become visible one clock edge later, so every acknowledge is followed by register reads and interrupt checks in the next cycle.

// File: rtl/irqm_pkg.sv
// Package irqm_pkg
// Shared widths, register select codes and the level-open rule.
// Assumes 3-bit levels and a 4-bit mask field.
package irqm_pkg;
    localparam int LVL_W  = 3;
    localparam int MASK_W = 4;

    typedef enum logic [1:0] {
        RA_CUR   = 2'd0,
        RA_SAVED = 2'd1,
        RA_CFG   = 2'd2,
        RA_NONE  = 2'd3
    } reg_sel_e;

    // True when a request of level lvl may pass under mask value msk.
    function automatic logic lvl_open(input logic [MASK_W-1:0] msk,
                                      input logic [LVL_W-1:0]  lvl);
        if (msk == 4'hF)
            return lvl != '0;
        else if (msk[MASK_W-1])
            return 1'b0;
        else
            return {1'b0, lvl} > msk;
    endfunction
endpackage

// File: rtl/irqm_filter.sv
// Module irqm_filter
// Marks every source that is pending and whose level passes the mask.
// Assumes levels are packed 3 bits per source.
module irqm_filter
    import irqm_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic [NSRC-1:0]       pend,
    input  logic [NSRC*LVL_W-1:0] levels,
    input  logic [MASK_W-1:0]     cur_mask,
    output logic [NSRC-1:0]       open_vec
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // Open flag of one source.
        always_comb open_vec[g] = pend[g] && lvl_open(cur_mask, levels[g*LVL_W +: LVL_W]);
    end
endmodule

// File: rtl/irqm_pick.sv
// Module irqm_pick
// Selects the open source with the highest level. A tie goes to the lowest index.
// Assumes that open_vec already applies the mask.
module irqm_pick
    import irqm_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = 3
) (
    input  logic [NSRC-1:0]       open_vec,
    input  logic [NSRC*LVL_W-1:0] levels,
    output logic                  win_valid,
    output logic [IDX_W-1:0]      win_idx,
    output logic [LVL_W-1:0]      win_lvl
);
    // Downward scan: ">=" lets a lower index take over on an equal level.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (open_vec[i] && (!win_valid || levels[i*LVL_W +: LVL_W] >= win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_lvl   = levels[i*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/irqm_regs.sv
// Module irqm_regs
// Holds the current mask, the saved mask and the auto-mask enable.
// An applied acknowledge takes priority over a software write to either mask.
// Assumes ack_take is asserted only when a winner exists and the enable is set.
module irqm_regs
    import irqm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              ack_take,
    input  logic [LVL_W-1:0]  ack_lvl,
    output logic [MASK_W-1:0] cur_mask,
    output logic [MASK_W-1:0] saved_mask,
    output logic              auto_en
);
    // Register update: reset, then the software write, then the acknowledge override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mask   <= 4'hF;
            saved_mask <= '0;
            auto_en    <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_sel_e'(reg_addr))
                    RA_CUR:   cur_mask   <= reg_wdata[MASK_W-1:0];
                    RA_SAVED: saved_mask <= reg_wdata[MASK_W-1:0];
                    RA_CFG:   auto_en    <= reg_wdata[0];
                    default:  ;
                endcase
            end
            if (ack_take) begin
                cur_mask   <= {1'b0, ack_lvl};
                saved_mask <= cur_mask;
            end
        end
    end

    p_ack_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> (cur_mask == {1'b0, $past(ack_lvl)}) && (saved_mask == $past(cur_mask)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_take && !reg_wr) |=> $stable(cur_mask) && $stable(saved_mask));
endmodule

// File: rtl/irq_level_gate.sv
// Module irq_level_gate
// Top level: filters level-tagged requests with the current mask, drives the
// interrupt line, answers acknowledge reads with a vector and, when enabled,
// raises the mask on each acknowledge and keeps the old mask.
// Assumes a single controller instance and a combinational register read.
module irq_level_gate
    import irqm_pkg::*;
#(
    parameter int         NSRC     = 8,
    parameter int         VEC_W    = 8,
    parameter logic [7:0] VEC_BASE = 8'h40,
    parameter logic [7:0] SPUR_VEC = 8'h18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       req_pend,
    input  logic [NSRC*LVL_W-1:0] req_level,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic                  ack_req,
    output logic [VEC_W-1:0]      ack_vector,
    output logic                  irq_out
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0]   open_vec;
    logic [MASK_W-1:0] cur_mask;
    logic [MASK_W-1:0] saved_mask;
    logic              auto_en;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic [LVL_W-1:0]  win_lvl;
    logic              ack_take;

    irqm_filter #(.NSRC(NSRC)) u_filter (
        .pend     (req_pend),
        .levels   (req_level),
        .cur_mask (cur_mask),
        .open_vec (open_vec)
    );

    irqm_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
        .open_vec  (open_vec),
        .levels    (req_level),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    // Applied acknowledge: auto-mask enabled and a winner exists.
    always_comb ack_take = ack_req && auto_en && win_valid;

    irqm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .ack_take   (ack_take),
        .ack_lvl    (win_lvl),
        .cur_mask   (cur_mask),
        .saved_mask (saved_mask),
        .auto_en    (auto_en)
    );

    // Interrupt line: any open source.
    always_comb irq_out = |open_vec;

    // Vector: base plus winner index, or the spurious code.
    always_comb ack_vector = win_valid ? VEC_W'(VEC_BASE + 8'(win_idx)) : VEC_W'(SPUR_VEC);

    // Register read mux with reserved bits forced to zero.
    always_comb begin
        case (reg_sel_e'(reg_addr))
            RA_CUR:   reg_rdata = {4'h0, cur_mask};
            RA_SAVED: reg_rdata = {4'h0, saved_mask};
            RA_CFG:   reg_rdata = {7'h0, auto_en};
            default:  reg_rdata = 8'h00;
        endcase
    end

    p_irq_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == win_valid);

    p_win_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> lvl_open(cur_mask, win_lvl));

    p_spur_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !win_valid) |=> $stable(cur_mask) && $stable(saved_mask) || $past(reg_wr));

    p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mask[3] && cur_mask != 4'hF) |-> !irq_out);
endmodule

// File: tb/test_irq_level_gate.sv
module test_irq_level_gate;
    localparam int NSRC = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   req_pend = '0;
    logic [NSRC*3-1:0] req_level = '0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [7:0]        reg_wdata = 8'h00;
    logic [7:0]        reg_rdata;
    logic              ack_req = 1'b0;
    logic [7:0]        ack_vector;
    logic              irq_out;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    irq_level_gate i_irq_level_gate (
        .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .req_level(req_level),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ack_req(ack_req), .ack_vector(ack_vector), .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic bit passes(input int m, input int l);
        if (l == 0) return 1'b0;
        if (m == 15) return 1'b1;
        if (m >= 8) return 1'b0;
        return l > m;
    endfunction

    function automatic int exp_vec(input logic [NSRC-1:0] p, input logic [NSRC*3-1:0] lv, input int m);
        int best = -1;
        int bl = 0;
        for (int i = 0; i < NSRC; i++) begin
            int l = int'(lv[i*3 +: 3]);
            if (p[i] && passes(m, l) && l > bl) begin best = i; bl = l; end
        end
        return (best < 0) ? 'h18 : 'h40 + best;
    endfunction

    // Acknowledge for one cycle, returning the combinational vector.
    task automatic ack(output logic [7:0] v);
        @(negedge clk);
        ack_req = 1'b1;
        #1 v = ack_vector;
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, v;
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(2'd0, d); check("R1 cur", d, 'h0F);
        rd(2'd1, d); check("R1 saved", d, 'h00);
        rd(2'd2, d); check("R1 cfg", d, 'h00);
        check("R1 irq", irq_out, 0);

        // R2 field widths and the unused address
        wr(2'd0, 8'hA3); rd(2'd0, d); check("R2 cur bits", d, 'h03);
        wr(2'd1, 8'hF5); rd(2'd1, d); check("R2 saved bits", d, 'h05);
        wr(2'd2, 8'hFF); rd(2'd2, d); check("R2 cfg bit", d, 'h01);
        wr(2'd3, 8'hFF); rd(2'd3, d); check("R2 addr3", d, 'h00);
        wr(2'd2, 8'h00);

        // R3/R4/R5 sweep: every mask against every level on one source
        for (int m = 0; m < 16; m++) begin
            wr(2'd0, 8'(m));
            rd(2'd0, d); check("R4 stored as written", d, m);
            for (int l = 0; l < 8; l++) begin
                req_pend = 8'h04; req_level = '0; req_level[6 +: 3] = 3'(l);
                #1;
                if (l == 0) check("R5 level0", irq_out, 0);
                else if (m >= 8) check("R4 mask F/reserved", irq_out, passes(m, l));
                else check("R3 level>mask", irq_out, passes(m, l));
                req_pend = 8'h00; #1;
                check("R5 not pending", irq_out, 0);
            end
        end

        // R6 pseudo-random patterns: winner and interrupt line
        lf = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            wr(2'd0, {4'h0, lf[3:0]});
            req_pend = lf[11:4];
            req_level = {lf, lf[15:8]} ^ {3{lf[7:0]}};
            #1;
            check("R6 vector", ack_vector, exp_vec(req_pend, req_level, int'(lf[3:0])));
            check("R3 irq pattern", irq_out, exp_vec(req_pend, req_level, int'(lf[3:0])) != 'h18);
        end

        // R7 applied acknowledge: ties at level 6 go to source 5
        wr(2'd0, 8'h0F); wr(2'd1, 8'h00); wr(2'd2, 8'h01);
        req_pend = 8'b0110_0010; req_level = '0;
        req_level[3 +: 3] = 3'd3; req_level[15 +: 3] = 3'd6; req_level[18 +: 3] = 3'd6;
        ack(v); check("R6 tie lowest index", v, 'h45);
        rd(2'd0, d); check("R7 cur raised", d, 'h06);
        rd(2'd1, d); check("R7 saved old", d, 'h0F);
        check("R7 irq blocked", irq_out, 0);

        // R9 spurious acknowledge
        ack(v); check("R9 spurious vector", v, 'h18);
        rd(2'd0, d); check("R9 cur kept", d, 'h06);
        rd(2'd1, d); check("R9 saved kept", d, 'h0F);

        // R10 restore saved mask
        rd(2'd1, d); wr(2'd0, d);
        #1 check("R10 irq back", irq_out, 1);
        check("R10 vector back", ack_vector, 'h45);

        // R8 auto-mask disabled
        wr(2'd2, 8'h00); wr(2'd1, 8'h02);
        ack(v); check("R8 vector", v, 'h45);
        rd(2'd0, d); check("R8 cur kept", d, 'h0F);
        rd(2'd1, d); check("R8 saved kept", d, 'h02);

        // R11 write and applied acknowledge in the same cycle
        wr(2'd2, 8'h01);
        @(negedge clk);
        ack_req = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h01;
        @(negedge clk);
        ack_req = 1'b0; reg_wr = 1'b0;
        rd(2'd0, d); check("R11 ack wins cur", d, 'h06);
        rd(2'd1, d); check("R11 ack sets saved", d, 'h0F);

        // R11 write alongside a spurious acknowledge
        wr(2'd0, 8'h07);
        @(negedge clk);
        ack_req = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h03;
        @(negedge clk);
        ack_req = 1'b0; reg_wr = 1'b0;
        rd(2'd0, d); check("R11 write applies", d, 'h03);
        rd(2'd1, d); check("R11 saved untouched", d, 'h0F);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule